// File: doc/BRIEF.md
# Receive Page Ring Manager

This block stores incoming frames into a circular receive region of packet memory that is cut into 256-byte pages. The region runs from a programmable first page up to, but not including, a programmable end page; when writing passes the last page it continues at the first page. Each stored frame starts on a fresh page, the current page. The frame bytes go in from byte 4 of that page onward. The first four bytes are reserved for a header that the block writes only after the last byte has arrived: a status byte, the page where the next frame will begin, and the stored byte count.

A host-owned boundary page marks data that has not been read yet. If the frame would need to enter that page, storing stops at once. The rest of the frame is taken in and thrown away, the frame is reported as missed, and two sticky status bits are raised. While these bits stand, further frames are discarded. The host releases them by changing the boundary. In monitor mode frames are taken in and counted as missed, but nothing is written.

Frame bytes arrive on a valid/ready stream. A byte moves when `s_valid` and `s_ready` are both high at a rising clock edge, and `s_last` marks the final byte. `s_ready` is high at all times except during the four cycles in which the header is written. The source must hold `s_data`, `s_last` and `s_err` steady while `s_valid` is high and `s_ready` is low. The memory port has no back-pressure and takes one write per cycle.

Top module: `rxr_ring_mgr`

## Requirements
- R1: Every memory write targets a page p with first page <= p < end page (mem_addr[15:8] is the page, mem_addr[7:0] the byte offset); the page after end page minus one is the first page.
- R2: Byte k (from 0) of a stored frame is written at position k+4 counted linearly from offset 0 of the current page, moving to the next ring page every 256 positions.
- R3: After the last byte, the header is written at offsets 0..3 of the frame's first page. Offset 0 holds the status: bit 0 = 1 and bit 1 = 0 when s_err was low on the last byte, and bit 0 = 0 and bit 1 = 1 when it was high. Offset 1 holds the next-frame page. Offset 2 holds the low byte of (frame length + 4) and offset 3 its high byte.
- R4: When a frame is stored, curr_page moves to the ring page after the last page used and rx_status bit 0 pulses high for one cycle. curr_page changes at no other time except through R10.
- R5: If a byte would be written into a page equal to the boundary input (at frame start or at a page crossing), that byte and the rest of the frame are not written. rx_status bit 4 (overwrite) and bit 7 (halted) become set, rx_status bit 2 (missed) pulses for one cycle after the last byte, and curr_page is unchanged.
- R6: While rx_status bit 7 is set, frames are accepted and discarded with no memory write and reported as missed.
- R7: rx_status bits 4 and 7 clear on the clock edge after the boundary input changes value. A frame whose first byte is accepted in that same edge is still judged against the old halted state and is dropped.
- R8: While monitor is high when a frame's first byte is accepted, the frame produces no memory write, is reported missed, and leaves curr_page unchanged.
- R9: s_ready is low for exactly the four header-write cycles following the last byte of a stored frame and high otherwise.
- R10: After reset curr_page is 0, rx_status is 0 and s_ready is 1. curr_wr loads curr_wdata into curr_page only when no frame is in progress and no byte is accepted in that cycle; otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pstart | input | 8 | First page of the receive region |
| cfg_pstop | input | 8 | Page just past the receive region |
| bnry | input | 8 | Host boundary page (oldest unread) |
| curr_wr | input | 1 | Load strobe for the current page |
| curr_wdata | input | 8 | Value loaded into the current page |
| monitor | input | 1 | Check-only mode: store nothing |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Block can take a frame byte |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Final byte of the frame |
| s_err | input | 1 | Frame error flag, sampled with the final byte |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address {page, offset} |
| mem_wdata | output | 8 | Packet memory write data |
| curr_page | output | 8 | Page where the next frame will start |
| rx_status | output | 8 | bit0 stored pulse, bit2 missed pulse, bit4 overwrite, bit7 halted |

## Verification
Two events can land in the same cycle. One is the boundary change that releases the halted state. The other is the first byte of a new frame, which decides from that state whether the frame is stored. The bench provokes this by driving a new boundary value on the very cycle the first byte of a frame is presented while the block is halted. It then expects the frame to be dropped with no memory writes, and the overwrite and halted bits to read clear once the frame has ended. The bench also checks that the next frame is stored normally, which shows the release took effect without losing the collided frame's accounting.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_DROP = 2'd2,
    ST_HDR  = 2'd3
  } rx_state_e;

  localparam int HDR_BYTES   = 4;
  localparam int STAT_STORED = 0;
  localparam int STAT_MISSED = 2;
  localparam int STAT_OVW    = 4;
  localparam int STAT_HALT   = 7;
endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] cur,
  input  logic [PAGE_W-1:0] pstart,
  input  logic [PAGE_W-1:0] pstop,
  output logic [PAGE_W-1:0] nxt
);
  logic [PAGE_W-1:0] inc;
  assign inc = cur + {{(PAGE_W-1){1'b0}}, 1'b1};
  assign nxt = (inc == pstop) ? pstart : inc;
endmodule

// File: rtl/rxr_hdr_pack.sv
module rxr_hdr_pack #(
  parameter int PAGE_W = 8
) (
  input  logic [1:0]        idx,
  input  logic [7:0]        stat,
  input  logic [PAGE_W-1:0] nxt_page,
  input  logic [15:0]       cnt,
  output logic [7:0]        hbyte
);
  always_comb begin
    unique case (idx)
      2'd0:    hbyte = stat;
      2'd1:    hbyte = 8'(nxt_page);
      2'd2:    hbyte = cnt[7:0];
      default: hbyte = cnt[15:8];
    endcase
  end
endmodule

// File: rtl/rxr_hold_flag.sv
module rxr_hold_flag #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic [PAGE_W-1:0] bnry_i,
  output logic              flag_o
);
  logic [PAGE_W-1:0] bnry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnry_q <= '0;
      flag_o <= 1'b0;
    end else begin
      bnry_q <= bnry_i;
      if (set_i)                flag_o <= 1'b1;
      else if (bnry_i != bnry_q) flag_o <= 1'b0;
    end
  end

  // R5: an overwrite event always leaves the flag raised
  assert_flag_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int LEN_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PAGE_W-1:0]       cfg_pstart,
  input  logic [PAGE_W-1:0]       cfg_pstop,
  input  logic [PAGE_W-1:0]       bnry,
  input  logic                    curr_wr,
  input  logic [PAGE_W-1:0]       curr_wdata,
  input  logic                    monitor,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [7:0]              s_data,
  input  logic                    s_last,
  input  logic                    s_err,
  output logic                    mem_we,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic [7:0]              mem_wdata,
  output logic [PAGE_W-1:0]       curr_page,
  output logic [7:0]              rx_status
);
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_HDR  = LEN_W'(HDR_BYTES);

  rx_state_e         state_q;
  logic [PAGE_W-1:0] curr_q, wr_page_q, tgt_page, step_nxt;
  logic [OFF_W-1:0]  wr_off_q, tgt_off;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        hdr_idx_q;
  logic              err_q, stored_q, missed_q, halt;
  logic              accept, frame_ok, in_frame, enter, hit, store_byte, ovf;
  logic [7:0]        hdr_byte, hdr_stat;
  logic [15:0]       hdr_cnt;

  rxr_page_step #(.PAGE_W(PAGE_W)) u_step (
    .cur(wr_page_q), .pstart(cfg_pstart), .pstop(cfg_pstop), .nxt(step_nxt)
  );

  assign hdr_stat = {6'b0, err_q, ~err_q};
  assign hdr_cnt  = 16'(len_q + LEN_HDR);

  rxr_hdr_pack #(.PAGE_W(PAGE_W)) u_hdr (
    .idx(hdr_idx_q), .stat(hdr_stat), .nxt_page(step_nxt), .cnt(hdr_cnt), .hbyte(hdr_byte)
  );

  rxr_hold_flag #(.PAGE_W(PAGE_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(ovf), .bnry_i(bnry), .flag_o(halt)
  );

  assign s_ready  = (state_q != ST_HDR);
  assign accept   = s_valid & s_ready;
  assign frame_ok = ~monitor & ~halt;
  assign in_frame = (state_q == ST_DATA) | ((state_q == ST_IDLE) & frame_ok);

  always_comb begin
    if (state_q == ST_IDLE) begin
      enter    = 1'b1;
      tgt_page = curr_q;
      tgt_off  = DATA_OFF;
    end else begin
      enter    = (wr_off_q == '0);
      tgt_page = enter ? step_nxt : wr_page_q;
      tgt_off  = wr_off_q;
    end
  end

  assign hit        = enter & (tgt_page == bnry);
  assign store_byte = accept & in_frame & ~hit;
  assign ovf        = accept & in_frame & hit;

  assign mem_we    = store_byte | (state_q == ST_HDR);
  assign mem_addr  = (state_q == ST_HDR) ? {curr_q, OFF_W'(hdr_idx_q)} : {tgt_page, tgt_off};
  assign mem_wdata = (state_q == ST_HDR) ? hdr_byte : s_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      curr_q    <= '0;
      wr_page_q <= '0;
      wr_off_q  <= '0;
      len_q     <= '0;
      hdr_idx_q <= '0;
      err_q     <= 1'b0;
      stored_q  <= 1'b0;
      missed_q  <= 1'b0;
    end else begin
      stored_q <= 1'b0;
      missed_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_DATA: begin
          if (store_byte) begin
            wr_page_q <= tgt_page;
            wr_off_q  <= tgt_off + {{(OFF_W-1){1'b0}}, 1'b1};
            len_q     <= (state_q == ST_IDLE) ? LEN_ONE : len_q + LEN_ONE;
            err_q     <= s_err;
            hdr_idx_q <= '0;
            state_q   <= s_last ? ST_HDR : ST_DATA;
          end else if (accept) begin
            if (s_last) begin
              missed_q <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              state_q  <= ST_DROP;
            end
          end else if (curr_wr && state_q == ST_IDLE) begin
            curr_q <= curr_wdata;
          end
        end
        ST_DROP: begin
          if (accept && s_last) begin
            missed_q <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: begin
          hdr_idx_q <= hdr_idx_q + 2'd1;
          if (hdr_idx_q == 2'd3) begin
            curr_q   <= step_nxt;
            stored_q <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign curr_page = curr_q;
  always_comb begin
    rx_status              = '0;
    rx_status[STAT_STORED] = stored_q;
    rx_status[STAT_MISSED] = missed_q;
    rx_status[STAT_OVW]    = halt;
    rx_status[STAT_HALT]   = halt;
  end

  // R1: writes stay inside the configured region when the start page lies in it
  assert_in_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cfg_pstart < cfg_pstop && curr_q >= cfg_pstart && curr_q < cfg_pstop)
    |-> (mem_addr[ADDR_W-1:OFF_W] >= cfg_pstart && mem_addr[ADDR_W-1:OFF_W] < cfg_pstop));

  // R5: a data write that opens a page never lands on the boundary page
  assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state_q != ST_HDR && (state_q == ST_IDLE || mem_addr[OFF_W-1:0] == '0))
    |-> (mem_addr[ADDR_W-1:OFF_W] != bnry));

  // R6: halted block never starts writing a frame
  assert_halt_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && halt) |-> !mem_we);

  // R8: monitor mode never starts writing a frame
  assert_monitor_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && monitor) |-> !mem_we);

  // R4: current page moves only after a header or through a load
  assert_curr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(curr_q) |-> ($past(state_q) == ST_HDR || $past(curr_wr)));

  // R4: a frame ends either stored or missed, never both
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stored_q && missed_q));
endmodule

// File: tb/sim_rxr_ring_mgr.sv
module sim_rxr_ring_mgr;
  localparam logic [7:0] PS = 8'h40;
  localparam logic [7:0] PE = 8'h48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  cfg_pstart = PS, cfg_pstop = PE, bnry = 8'h00, curr_wdata = 8'h00;
  logic        curr_wr = 1'b0, monitor = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        s_ready, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, curr_page, rx_status;

  rxr_ring_mgr u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pstart(cfg_pstart), .cfg_pstop(cfg_pstop),
    .bnry(bnry), .curr_wr(curr_wr), .curr_wdata(curr_wdata), .monitor(monitor),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_err(s_err), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .curr_page(curr_page), .rx_status(rx_status)
  );

  logic [7:0] bmem [0:2047];
  int wcount = 0, oob = 0;
  always @(posedge clk) begin
    if (mem_we) begin
      wcount++;
      if (mem_addr[15:8] >= PS && mem_addr[15:8] < PE) bmem[11'(mem_addr - 16'h4000)] <= mem_wdata;
      else oob++;
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nextp(logic [7:0] p);
    return (p + 8'd1 == PE) ? PS : p + 8'd1;
  endfunction
  function automatic logic [7:0] prevp(logic [7:0] p);
    return (p == PS) ? PE - 8'd1 : p - 8'd1;
  endfunction
  function automatic int npages(int len);
    return (len + 4 + 255) / 256;
  endfunction
  function automatic bit fits(logic [7:0] c, int len, logic [7:0] b);
    logic [7:0] p = c;
    for (int i = 0; i < npages(len); i++) begin
      if (p == b) return 1'b0;
      p = nextp(p);
    end
    return 1'b1;
  endfunction
  function automatic logic [7:0] endpg(logic [7:0] c, int len);
    logic [7:0] p = c;
    for (int i = 1; i < npages(len); i++) p = nextp(p);
    return nextp(p);
  endfunction
  function automatic int memidx(logic [7:0] p, int off);
    return (int'(p) - int'(PS)) * 256 + off;
  endfunction

  logic [7:0] fb [0:1023];
  bit got_stored, got_missed, rdy_after;

  task automatic send(int len, bit err, bit poke, bit bswap, logic [7:0] bnew);
    for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fb[k]; s_last = (k == len - 1);
      s_err = err && (k == len - 1);
      curr_wr = poke && (k == 2); curr_wdata = 8'h44;
      if (bswap && k == 0) bnry = bnew;
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0; curr_wr = 1'b0;
    rdy_after = s_ready;
    got_stored = 0; got_missed = 0;
    for (int i = 0; i < 20; i++) begin
      if (rx_status[0]) got_stored = 1;
      if (rx_status[2]) got_missed = 1;
      if (got_stored || got_missed) break;
      @(negedge clk);
    end
  endtask

  task automatic check_stored(logic [7:0] c0, int len, bit err);
    int i0 = memidx(c0, 0);
    int bad = 0;
    chk(got_stored && !got_missed, "R4 stored pulse", got_stored, 1);
    chk(curr_page == endpg(c0, len), "R4 next current page", curr_page, endpg(c0, len));
    chk(bmem[i0] == (err ? 8'h02 : 8'h01), "R3 status byte", bmem[i0], err ? 2 : 1);
    chk(bmem[i0+1] == endpg(c0, len), "R3 next page byte", bmem[i0+1], endpg(c0, len));
    chk(bmem[i0+2] == 8'((len + 4) & 255), "R3 count low", bmem[i0+2], (len + 4) & 255);
    chk(bmem[i0+3] == 8'((len + 4) >> 8), "R3 count high", bmem[i0+3], (len + 4) >> 8);
    for (int k = 0; k < len; k++) begin
      logic [7:0] p = c0;
      for (int j = 0; j < (k + 4) / 256; j++) p = nextp(p);
      if (bmem[memidx(p, (k + 4) % 256)] != fb[k]) bad++;
    end
    chk(bad == 0, "R2 data placement", bad, 0);
    chk(oob == 0, "R1 writes inside region", oob, 0);
  endtask

  task automatic load_curr(logic [7:0] v);
    @(negedge clk); curr_wr = 1'b1; curr_wdata = v;
    @(negedge clk); curr_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired (R9 progress): actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0;
    int wc, len;
    bit err, exp_fit;
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(curr_page == 8'h00, "R10 reset current page", curr_page, 0);
    chk(rx_status == 8'h00, "R10 reset status", rx_status, 0);
    chk(s_ready && !mem_we, "R10 reset ready/idle", {s_ready, mem_we}, 2);
    load_curr(PS);
    chk(curr_page == PS, "R10 current page load", curr_page, PS);
    bnry = prevp(PS);

    // single-byte frame, R9 header stall
    c0 = curr_page; send(1, 1'b0, 1'b0, 1'b0, 8'h00);
    chk(rdy_after == 1'b0, "R9 ready low during header", rdy_after, 0);
    check_stored(c0, 1, 1'b0);

    // R1 wrap from last page to first
    bnry = 8'h46; load_curr(8'h47);
    c0 = curr_page; send(300, 1'b0, 1'b0, 1'b0, 8'h00);
    check_stored(c0, 300, 1'b0);
    chk(curr_page == 8'h41, "R1 wrap next page", curr_page, 8'h41);

    // exact single-page fit: count 0x100
    bnry = prevp(curr_page); @(negedge clk);
    c0 = curr_page; send(252, 1'b0, 1'b0, 1'b0, 8'h00);
    check_stored(c0, 252, 1'b0);

    // errored frame status
    bnry = prevp(curr_page); @(negedge clk);
    c0 = curr_page; send(70, 1'b1, 1'b0, 1'b0, 8'h00);
    check_stored(c0, 70, 1'b1);

    // R8 monitor mode
    monitor = 1'b1; c0 = curr_page; wc = wcount;
    send(50, 1'b0, 1'b0, 1'b0, 8'h00);
    chk(got_missed && !got_stored, "R8 monitor frame missed", got_missed, 1);
    chk(wcount == wc, "R8 monitor no writes", wcount - wc, 0);
    chk(curr_page == c0, "R8 monitor current page kept", curr_page, c0);
    monitor = 1'b0;

    // R5 overwrite at a page crossing
    c0 = curr_page; bnry = nextp(c0); @(negedge clk); wc = wcount;
    send(400, 1'b0, 1'b0, 1'b0, 8'h00);
    chk(got_missed, "R5 overwrite frame missed", got_missed, 1);
    chk(rx_status[4] && rx_status[7], "R5 overwrite and halted bits", rx_status, 8'h90);
    chk(curr_page == c0, "R5 current page kept", curr_page, c0);
    chk(wcount - wc == 252, "R5 writes stop at boundary", wcount - wc, 252);

    // R6 halted frame dropped
    wc = wcount; send(20, 1'b0, 1'b0, 1'b0, 8'h00);
    chk(got_missed && wcount == wc, "R6 halted frame dropped", wcount - wc, 0);

    // R7 release collides with a frame start
    wc = wcount; send(20, 1'b0, 1'b0, 1'b1, prevp(curr_page));
    chk(got_missed && wcount == wc, "R7 collided frame dropped", wcount - wc, 0);
    chk(rx_status[7:4] == 4'h0, "R7 flags cleared", rx_status, 0);
    c0 = curr_page; send(100, 1'b0, 1'b0, 1'b0, 8'h00);
    check_stored(c0, 100, 1'b0);

    // R10 load ignored mid-frame
    bnry = prevp(curr_page); @(negedge clk);
    c0 = curr_page; send(30, 1'b0, 1'b1, 1'b0, 8'h00);
    check_stored(c0, 30, 1'b0);
    chk(curr_page == endpg(c0, 30), "R10 mid-frame load ignored", curr_page, endpg(c0, 30));

    // random frames with a lagging reader
    for (int it = 0; it < 30; it++) begin
      if ($urandom % 2 == 0) bnry = prevp(curr_page);
      @(negedge clk);
      len = 1 + int'($urandom % 600);
      err = 1'($urandom % 2);
      c0 = curr_page;
      exp_fit = fits(c0, len, bnry);
      send(len, err, 1'b0, 1'b0, 8'h00);
      if (exp_fit) check_stored(c0, len, err);
      else begin
        chk(got_missed && rx_status[4], "R5 random overwrite", rx_status, 8'h90);
        chk(curr_page == c0, "R5 random current page kept", curr_page, c0);
        bnry = prevp(curr_page);
        @(negedge clk); @(negedge clk);
        chk(rx_status[7] == 1'b0, "R7 random release", rx_status, 0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule